// File: doc/BRIEF.md
# Spare-Area Chunk Splitter

This block turns a byte range inside a flash page's spare (out-of-band) area into a list of accesses. Each access targets one of eight fixed on-chip spare buffers. A request gives a geometry code, a start offset and a byte count. The block then emits one descriptor for each piece of the range that lands in one buffer. A descriptor carries the buffer number, the byte position inside that buffer, the piece length and the absolute local address of the first byte. The block moves no data. A copy engine walks the descriptors and does the transfers.

A page's spare bytes are shared out over one buffer per 512-byte main sector. The share per buffer is the spare size divided by the sector count, forced down to an even number. Every offset past the seventh full share falls into the last buffer. For that reason, buffer 7 absorbs any piece that starts in it, however long the piece is.

Both streams use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no request is in progress. A descriptor is presented with `desc_valid` and holds every field steady until the cycle where `desc_ready` is also high. The consumer may stall for any number of cycles. `done` is a plain one-cycle status pulse.

Top module: `spare_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `desc_valid` is 0 and `done` is 0.
- R2: The per-buffer share follows `req_cfg`: 0 = page 512 / spare 16 gives 16 bytes; 1 = 2048 / 64 gives 16; 2 = 4096 / 128 gives 16; 3 = 4096 / 218 gives 26 (27 rounded down to even).
- R3: `desc_buf` equals the current offset divided by the share, limited to at most 7, and it rises from one descriptor to the next within a request.
- R4: `desc_inner` equals the current offset minus `desc_buf` times the share.
- R5: Below buffer 7, `desc_len` is the smaller of (share − `desc_inner`) and the bytes still remaining. In buffer 7 it is all remaining bytes. It is never zero.
- R6: `desc_addr` equals 0x1000 + `desc_buf` × 0x40 + `desc_inner`.
- R7: While `desc_valid` is 1 and `desc_ready` is 0, every descriptor field holds. After each accepted descriptor, the offset advances and the remaining count falls by `desc_len`.
- R8: `done` is 1 for exactly one cycle, in the cycle after the last descriptor of a request is accepted. `desc_valid` is 0 in that cycle.
- R9: A request with `req_len` = 0 produces no descriptor. `done` is 1 in the cycle after the request is accepted.
- R10: `req_ready` is 0 while a request is in progress. Request inputs presented then do not change the descriptors of the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Splitter idle, request can be taken |
| req_cfg | input | 2 | Page/spare geometry code (see R2) |
| req_offset | input | 8 | Start byte within the spare area |
| req_len | input | 8 | Byte count |
| desc_valid | output | 1 | Descriptor present |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_buf | output | 3 | Spare buffer number |
| desc_inner | output | 8 | Byte position inside that buffer |
| desc_len | output | 8 | Bytes in this piece |
| desc_addr | output | 13 | Local address of the piece's first byte |
| done | output | 1 | One-cycle pulse when a request finishes |

## Verification
The bench sweeps every start offset from 0 to 239 under all four geometry codes. For each offset it uses six lengths: zero, one byte, three bytes, one more than a share, exactly to the end of the spare area, and up to byte 255. One byte and three bytes test the inner offset and the clipping of a piece inside a buffer. One more than a share forces a crossing into the next buffer. The two long lengths walk through every boundary and into the clamp of buffer 7, where an oversize piece sets the final buffer apart from the rest. The consumer stalls every third cycle, so the hold rule is exercised. On alternate runs, a different request is held on the input while the splitter is busy, to show that it is ignored.

// File: rtl/spare_split_pkg.sv
package spare_split_pkg;

  // Geometry codes: page bytes / spare bytes.
  typedef enum logic [1:0] {
    GEOM_P512_S16  = 2'd0,
    GEOM_P2K_S64   = 2'd1,
    GEOM_P4K_S128  = 2'd2,
    GEOM_P4K_S218  = 2'd3
  } geom_e;

  typedef enum logic {
    SPL_IDLE = 1'b0,
    SPL_RUN  = 1'b1
  } spl_state_e;

endpackage

// File: rtl/spare_unit_lut.sv
module spare_unit_lut
  import spare_split_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  geom_e            geom,
  output logic [OFF_W-1:0] unit
);

  logic [OFF_W-1:0] spare_bytes;
  logic [1:0]       sect_log2;   // log2 of 512-byte sectors per page

  always_comb begin
    case (geom)
      GEOM_P512_S16: begin spare_bytes = OFF_W'(16);  sect_log2 = 2'd0; end
      GEOM_P2K_S64:  begin spare_bytes = OFF_W'(64);  sect_log2 = 2'd2; end
      GEOM_P4K_S128: begin spare_bytes = OFF_W'(128); sect_log2 = 2'd3; end
      default:       begin spare_bytes = OFF_W'(218); sect_log2 = 2'd3; end
    endcase
  end

  // Share per buffer: spare / sectors, forced even.
  assign unit = (spare_bytes >> sect_log2) & {{(OFF_W-1){1'b1}}, 1'b0};

endmodule

// File: rtl/spare_chunk_calc.sv
module spare_chunk_calc #(
  parameter int OFF_W   = 8,
  parameter int NUM_BUF = 8,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 13,
  parameter int BASE    = 'h1000,
  parameter int STRIDE  = 'h40
) (
  input  logic [OFF_W-1:0]  cur_off,
  input  logic [OFF_W-1:0]  remain,
  input  logic [OFF_W-1:0]  unit,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  inner,
  output logic [OFF_W-1:0]  clen,
  output logic [ADDR_W-1:0] addr
);

  localparam int PW = OFF_W + IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BUF - 1);

  // One threshold comparator per buffer boundary replaces a divider.
  logic [NUM_BUF-1:1] past_edge;

  genvar k;
  generate
    for (k = 1; k < NUM_BUF; k++) begin : g_edge
      assign past_edge[k] = PW'(cur_off) >= (PW'(k) * PW'(unit));
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int j = 1; j < NUM_BUF; j++) begin
      if (past_edge[j]) idx = idx + 1'b1;
    end
  end

  logic [PW-1:0]    buf_start;
  logic [OFF_W-1:0] room;

  assign buf_start = PW'(idx) * PW'(unit);
  assign inner     = OFF_W'(PW'(cur_off) - buf_start);
  assign room      = unit - inner;

  always_comb begin
    if (idx == LAST)        clen = remain;
    else if (room < remain) clen = room;
    else                    clen = remain;
  end

  assign addr = ADDR_W'(BASE) + ADDR_W'(idx) * ADDR_W'(STRIDE) + ADDR_W'(inner);

endmodule

// File: rtl/spare_splitter.sv
module spare_splitter
  import spare_split_pkg::*;
#(
  parameter int OFF_W   = 8,
  parameter int NUM_BUF = 8,
  parameter int ADDR_W  = 13,
  parameter int BASE    = 'h1000,
  parameter int STRIDE  = 'h40,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_cfg,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [OFF_W-1:0]  req_len,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [IDX_W-1:0]  desc_buf,
  output logic [OFF_W-1:0]  desc_inner,
  output logic [OFF_W-1:0]  desc_len,
  output logic [ADDR_W-1:0] desc_addr,
  output logic              done
);

  spl_state_e       state_q;
  geom_e            geom_q;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] rem_q;
  logic             done_q;
  logic [OFF_W-1:0] unit;
  logic [OFF_W-1:0] clen;

  spare_unit_lut #(.OFF_W(OFF_W)) u_lut (
    .geom (geom_q),
    .unit (unit)
  );

  spare_chunk_calc #(
    .OFF_W(OFF_W), .NUM_BUF(NUM_BUF), .IDX_W(IDX_W),
    .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
  ) u_calc (
    .cur_off (off_q),
    .remain  (rem_q),
    .unit    (unit),
    .idx     (desc_buf),
    .inner   (desc_inner),
    .clen    (clen),
    .addr    (desc_addr)
  );

  logic take_req, take_desc;
  assign req_ready  = (state_q == SPL_IDLE);
  assign desc_valid = (state_q == SPL_RUN);
  assign take_req   = req_valid & req_ready;
  assign take_desc  = desc_valid & desc_ready;
  assign desc_len   = clen;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SPL_IDLE;
      geom_q  <= GEOM_P512_S16;
      off_q   <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take_req) begin
        geom_q <= geom_e'(req_cfg);
        off_q  <= req_offset;
        rem_q  <= req_len;
        if (req_len == '0) done_q  <= 1'b1;
        else               state_q <= SPL_RUN;
      end else if (take_desc) begin
        off_q <= off_q + clen;
        rem_q <= rem_q - clen;
        if (rem_q == clen) begin
          state_q <= SPL_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spare_splitter_chk.sv
module spare_splitter_chk #(
  parameter int OFF_W  = 8,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [IDX_W-1:0]  desc_buf,
  input logic [OFF_W-1:0]  desc_inner,
  input logic [OFF_W-1:0]  desc_len,
  input logic [ADDR_W-1:0] desc_addr,
  input logic              done
);

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !req_ready);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=>
      (desc_valid && $stable(desc_buf) && $stable(desc_inner)
       && $stable(desc_len) && $stable(desc_addr)));

  p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_len != '0));

  p_buf_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready) |=> (!desc_valid || desc_buf > $past(desc_buf)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !desc_valid));

endmodule

bind spare_splitter spare_splitter_chk #(
  .OFF_W(OFF_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .desc_valid(desc_valid),
  .desc_ready(desc_ready), .desc_buf(desc_buf), .desc_inner(desc_inner),
  .desc_len(desc_len), .desc_addr(desc_addr), .done(done)
);

// File: tb/test_spare_splitter.sv
module test_spare_splitter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_cfg = '0;
  logic [7:0]  req_offset = '0;
  logic [7:0]  req_len = '0;
  logic        desc_valid;
  logic        desc_ready = 1'b0;
  logic [2:0]  desc_buf;
  logic [7:0]  desc_inner;
  logic [7:0]  desc_len;
  logic [12:0] desc_addr;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int stall_ctr = 0;

  always #5 clk = ~clk;

  spare_splitter i_spare_splitter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cfg(req_cfg), .req_offset(req_offset), .req_len(req_len),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_buf(desc_buf),
    .desc_inner(desc_inner), .desc_len(desc_len), .desc_addr(desc_addr),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int spare_of(input int cfg);
    case (cfg)
      0: return 16;
      1: return 64;
      2: return 128;
      default: return 218;
    endcase
  endfunction

  function automatic int unit_of(input int cfg);
    int sectors;
    case (cfg)
      0: sectors = 1;
      1: sectors = 4;
      default: sectors = 8;
    endcase
    return (spare_of(cfg) / sectors) & ~1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 200000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input int cfg, input int off, input int len, input bit noise);
    int u, o, r, idx, inner, cl, addr;
    bit go;
    u = unit_of(cfg);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", req_ready, 1);
    req_cfg = 2'(cfg); req_offset = 8'(off); req_len = 8'(len); req_valid = 1'b1;
    @(negedge clk);
    if (noise && len != 0) begin
      req_cfg = 2'(cfg + 1); req_offset = 8'(~off); req_len = 8'd5;
    end else begin
      req_valid = 1'b0;
    end
    if (len == 0) begin
      chk(done == 1'b1, "R9", done, 1);
      chk(desc_valid == 1'b0, "R9", desc_valid, 0);
      @(negedge clk);
      chk(done == 1'b0, "R8", done, 0);
      return;
    end
    o = off; r = len;
    while (r > 0) begin
      idx = o / u;
      if (idx > 7) idx = 7;
      inner = o - idx * u;
      if (idx == 7) cl = r;
      else cl = ((u - inner) < r) ? (u - inner) : r;
      addr = 'h1000 + idx * 'h40 + inner;
      for (int w = 0; w < 8; w++) begin
        chk(desc_valid == 1'b1, "R7", desc_valid, 1);
        chk(req_ready == 1'b0, "R10", req_ready, 0);
        chk(desc_buf == 3'(idx), "R3", desc_buf, idx);
        chk(desc_inner == 8'(inner), "R4", desc_inner, inner);
        chk(desc_len == 8'(cl), "R5", desc_len, cl);
        chk(desc_addr == 13'(addr), "R6", desc_addr, addr);
        if (idx < 7 && inner == 0 && r >= u)
          chk(desc_len == 8'(u), "R2", desc_len, u);
        go = (stall_ctr % 3) != 1;
        stall_ctr++;
        if (go && cl == r) req_valid = 1'b0;
        desc_ready = go;
        @(negedge clk);
        if (go) break;
      end
      o += cl; r -= cl;
    end
    desc_ready = 1'b0;
    chk(done == 1'b1, "R8", done, 1);
    chk(desc_valid == 1'b0, "R8", desc_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", done, 0);
  endtask

  initial begin
    int lens[6];
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    chk(desc_valid == 1'b0, "R1", desc_valid, 0);
    chk(done == 1'b0, "R1", done, 0);
    rst_n = 1'b1;
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int off = 0; off < 240; off++) begin
        lens[0] = 0;
        lens[1] = 1;
        lens[2] = 3;
        lens[3] = unit_of(cfg) + 1;
        lens[4] = (spare_of(cfg) > off) ? spare_of(cfg) - off : 2;
        lens[5] = 255 - off;
        for (int li = 0; li < 6; li++) begin
          run(cfg, off, lens[li], (off % 2) == 1);
        end
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule